// File: doc/BRIEF.md
# Dual Prescaled Down-Counting Timer

This peripheral holds two identical down-counting timers on a single synchronous register bus. Each timer has a 24-bit counter, a reload register and a small control word. The control word turns counting on, chooses between a repeating (periodic) run and a single (one-shot) run, and picks the tick rate: the input clock itself, the clock divided by 16, or the clock divided by 256.

When a timer expires it sets its own pending flag. The two flags are ORed into one registered interrupt line. Software drops a flag by writing any value to that timer's clear register.

A typical use gives one timer a repeating system tick and lets the other run free from the maximum load value, so that its descending count works as a time base.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset every readable register returns zero and `irq` is low.
- R2: Per-timer register offsets are 0x0 reload, 0x4 count, 0x8 control and 0xC clear. The second timer uses the same layout at 0x20. Address bit 4 set selects nothing. A read request returns its data on `bus_rdata` one clock later, zero-extended to 32 bits. Reading the clear register returns zero.
- R3: A write to the reload register stores the low 24 bits and copies them into the counter in the same cycle. A reload write takes priority over a tick in that cycle.
- R4: Control bit 7 enables counting, bit 6 selects periodic mode (clear means one-shot), and bits 3:2 select the prescaler. These bits read back from the control register, and all other bits read as zero.
- R5: Each prescaled tick lowers a nonzero count by one. With prescaler code 00 a tick occurs on every clock while the timer is enabled. A control write restarts the prescaler and produces no tick in its own cycle.
- R6: With prescaler code 01 the first tick comes 16 clocks after the control write. With code 10 the first tick comes 256 clocks after the control write, and code 11 behaves exactly like code 10.
- R7: A tick that finds the count at zero is an expiry. It sets the pending flag. In one-shot mode the count stays at zero and control bit 7 clears itself.
- R8: In periodic mode an expiry reloads the count from the reload register, so one period lasts reload+1 ticks.
- R9: A write of any data to a timer's clear register drops that timer's pending flag.
- R10: If an expiry and a clear write fall on the same cycle, the flag stays set.
- R11: `irq` is the OR of both pending flags, registered, so it follows a flag change by one clock.
- R12: With control and reload both zero, the count does not change and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq | output | 1 | Combined registered interrupt |

## Verification
The hardest case is an expiry landing in the same clock as a write to that timer's clear register. Timer B is loaded with 2 and started in periodic mode at full rate, so it expires every third clock. The bench places one clear write exactly on the second expiry and a second clear write on the following cycle. `irq` must stay high after the first clear, because the expiry wins, and must fall only after the second clear. A smaller overlap is also covered: a control write that lands on a cycle that would otherwise tick must suppress that tick, which the first count read after each start reveals.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W      = 32;
  localparam int CTRL_EN_BIT = 7;
  localparam int CTRL_PER_BIT = 6;
  localparam int CTRL_PS_LSB = 2;

  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_CLEAR  = 2'd3
  } tmr_reg_e;

  typedef struct packed {
    logic       run;
    logic       periodic;
    logic [1:0] psel;
  } tmr_ctrl_t;

  function automatic tmr_ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
    tmr_ctrl_t c;
    c.run      = w[CTRL_EN_BIT];
    c.periodic = w[CTRL_PER_BIT];
    c.psel     = w[CTRL_PS_LSB+1:CTRL_PS_LSB];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_to_word(input tmr_ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CTRL_EN_BIT] = c.run;
    w[CTRL_PER_BIT] = c.periodic;
    w[CTRL_PS_LSB+1:CTRL_PS_LSB] = c.psel;
    return w;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W    = 8,
  parameter int MID_LOG2 = 4,
  parameter int HI_LOG2  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] psel,
  output logic       tick
);
  localparam logic [PRE_W-1:0] LIM_MID = PRE_W'((1 << MID_LOG2) - 1);
  localparam logic [PRE_W-1:0] LIM_HI  = PRE_W'((1 << HI_LOG2) - 1);

  logic [PRE_W-1:0] div_cnt;
  logic [PRE_W-1:0] limit;

  always_comb begin
    case (psel)
      2'b00:   limit = '0;
      2'b01:   limit = LIM_MID;
      default: limit = LIM_HI;
    endcase
  end

  assign tick = run && !restart && (div_cnt == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
    end else if (restart || !run || (div_cnt == limit)) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload_wr,
  input  logic             ctrl_wr,
  input  logic             clear_wr,
  input  logic [CNT_W-1:0] wr_value,
  input  tmr_ctrl_t        wr_ctrl,
  output logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] count_q,
  output tmr_ctrl_t        ctrl_q,
  output logic             pend_q,
  output logic             tick
);
  logic at_zero;
  logic expire;

  tmr_prescaler #(
    .PRE_W(8),
    .MID_LOG2(4),
    .HI_LOG2(8)
  ) u_pre (
    .clk(clk),
    .rst(rst),
    .run(ctrl_q.run),
    .restart(ctrl_wr),
    .psel(ctrl_q.psel),
    .tick(tick)
  );

  assign at_zero = (count_q == '0);
  assign expire  = tick && at_zero && !reload_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= wr_ctrl;
    end else if (expire && !ctrl_q.periodic) begin
      ctrl_q.run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      count_q  <= '0;
    end else if (reload_wr) begin
      reload_q <= wr_value;
      count_q  <= wr_value;
    end else if (tick) begin
      if (!at_zero) begin
        count_q <= count_q - 1'b1;
      end else if (ctrl_q.periodic) begin
        count_q <= reload_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (expire) begin
      pend_q <= 1'b1;
    end else if (clear_wr) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int N_TMR  = 2
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [N_TMR-1:0]  reload_wr,
  output logic [N_TMR-1:0]  ctrl_wr,
  output logic [N_TMR-1:0]  clear_wr,
  output logic              rd_en,
  output logic [ADDR_W-6:0] rd_ch,
  output tmr_reg_e          rd_reg
);
  localparam int CH_W = ADDR_W - 5;

  logic [CH_W-1:0] ch_idx;
  logic            hit;
  tmr_reg_e        reg_idx;
  logic [1:0]      unused_byte_lanes;

  assign ch_idx            = bus_addr[ADDR_W-1:5];
  assign reg_idx           = tmr_reg_e'(bus_addr[3:2]);
  assign unused_byte_lanes = bus_addr[1:0];
  assign hit = bus_sel && !bus_addr[4] && (int'(ch_idx) < N_TMR);

  for (genvar g = 0; g < N_TMR; g++) begin : g_strobe
    logic mine;
    assign mine         = hit && bus_wr && (int'(ch_idx) == g);
    assign reload_wr[g] = mine && (reg_idx == REG_RELOAD);
    assign ctrl_wr[g]   = mine && (reg_idx == REG_CTRL);
    assign clear_wr[g]  = mine && (reg_idx == REG_CLEAR);
  end

  assign rd_en  = hit && !bus_wr;
  assign rd_ch  = ch_idx;
  assign rd_reg = reg_idx;
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int N_TMR  = 2,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  logic [N_TMR-1:0]            reload_wr_v;
  logic [N_TMR-1:0]            ctrl_wr_v;
  logic [N_TMR-1:0]            clear_wr_v;
  logic                        rd_en;
  logic [ADDR_W-6:0]           rd_ch;
  tmr_reg_e                    rd_reg;
  logic [N_TMR-1:0][CNT_W-1:0] reload_v;
  logic [N_TMR-1:0][CNT_W-1:0] count_v;
  tmr_ctrl_t [N_TMR-1:0]       ctrl_v;
  logic [N_TMR-1:0]            run_v;
  logic [N_TMR-1:0]            per_v;
  logic [N_TMR-1:0]            pend_v;
  logic [N_TMR-1:0]            tick_v;
  tmr_ctrl_t                   wr_ctrl;
  logic [DATA_W-1:0]           rdata_q;
  logic                        irq_q;
  logic [DATA_W-1:CNT_W]       unused_wdata_hi;

  assign wr_ctrl         = ctrl_from_word(bus_wdata);
  assign unused_wdata_hi = bus_wdata[DATA_W-1:CNT_W];

  tmr_decode #(
    .ADDR_W(ADDR_W),
    .N_TMR(N_TMR)
  ) u_dec (
    .bus_sel(bus_sel),
    .bus_wr(bus_wr),
    .bus_addr(bus_addr),
    .reload_wr(reload_wr_v),
    .ctrl_wr(ctrl_wr_v),
    .clear_wr(clear_wr_v),
    .rd_en(rd_en),
    .rd_ch(rd_ch),
    .rd_reg(rd_reg)
  );

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    tmr_channel #(
      .CNT_W(CNT_W)
    ) u_ch (
      .clk(clk),
      .rst(rst),
      .reload_wr(reload_wr_v[g]),
      .ctrl_wr(ctrl_wr_v[g]),
      .clear_wr(clear_wr_v[g]),
      .wr_value(bus_wdata[CNT_W-1:0]),
      .wr_ctrl(wr_ctrl),
      .reload_q(reload_v[g]),
      .count_q(count_v[g]),
      .ctrl_q(ctrl_v[g]),
      .pend_q(pend_v[g]),
      .tick(tick_v[g])
    );
    assign run_v[g] = ctrl_v[g].run;
    assign per_v[g] = ctrl_v[g].periodic;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      case (rd_reg)
        REG_RELOAD: rdata_q <= DATA_W'(reload_v[rd_ch]);
        REG_COUNT:  rdata_q <= DATA_W'(count_v[rd_ch]);
        REG_CTRL:   rdata_q <= ctrl_to_word(ctrl_v[rd_ch]);
        default:    rdata_q <= '0;
      endcase
    end else begin
      rdata_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= |pend_v;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/dual_tick_timer_chk.sv
module dual_tick_timer_chk #(
  parameter int N_TMR = 2,
  parameter int CNT_W = 24
) (
  input logic                        clk,
  input logic                        rst,
  input logic [N_TMR-1:0]            run_v,
  input logic [N_TMR-1:0]            per_v,
  input logic [N_TMR-1:0]            pend_v,
  input logic [N_TMR-1:0]            tick_v,
  input logic [N_TMR-1:0]            reload_wr_v,
  input logic [N_TMR-1:0]            clear_wr_v,
  input logic [N_TMR-1:0][CNT_W-1:0] count_v,
  input logic [N_TMR-1:0][CNT_W-1:0] reload_v,
  input logic                        irq
);
  for (genvar g = 0; g < N_TMR; g++) begin : g_chk
    assert_reload_copy_R3: assert property (@(posedge clk) disable iff (rst)
      reload_wr_v[g] |=> (count_v[g] == reload_v[g]));

    assert_tick_needs_run_R5: assert property (@(posedge clk) disable iff (rst)
      tick_v[g] |-> run_v[g]);

    assert_step_down_R5: assert property (@(posedge clk) disable iff (rst)
      (tick_v[g] && !reload_wr_v[g] && (count_v[g] != '0))
        |=> (count_v[g] == $past(count_v[g]) - 1'b1));

    assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (rst)
      (tick_v[g] && !reload_wr_v[g] && (count_v[g] == '0) && !per_v[g])
        |=> (!run_v[g] && (count_v[g] == '0) && pend_v[g]));

    assert_periodic_reload_R8: assert property (@(posedge clk) disable iff (rst)
      (tick_v[g] && !reload_wr_v[g] && (count_v[g] == '0) && per_v[g])
        |=> ((count_v[g] == $past(reload_v[g])) && pend_v[g]));

    assert_clear_drops_R9: assert property (@(posedge clk) disable iff (rst)
      (clear_wr_v[g] && !(tick_v[g] && !reload_wr_v[g] && (count_v[g] == '0)))
        |=> !pend_v[g]);

    assert_expiry_wins_R10: assert property (@(posedge clk) disable iff (rst)
      (clear_wr_v[g] && tick_v[g] && !reload_wr_v[g] && (count_v[g] == '0))
        |=> pend_v[g]);

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
      (!run_v[g] && !reload_wr_v[g]) |=> $stable(count_v[g]));
  end

  assert_irq_follows_R11: assert property (@(posedge clk) disable iff (rst)
    (|pend_v) |=> irq);

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !(|pend_v) |=> !irq);
endmodule

bind dual_tick_timer dual_tick_timer_chk #(
  .N_TMR(N_TMR),
  .CNT_W(CNT_W)
) u_chk (
  .clk(clk),
  .rst(rst),
  .run_v(run_v),
  .per_v(per_v),
  .pend_v(pend_v),
  .tick_v(tick_v),
  .reload_wr_v(reload_wr_v),
  .clear_wr_v(clear_wr_v),
  .count_v(count_v),
  .reload_v(reload_v),
  .irq(irq)
);

// File: tb/sim_dual_tick_timer.sv
`timescale 1ns/1ps
module sim_dual_tick_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t sb_q[$];
  logic rd_seen = 1'b0;

  always #4 clk = ~clk;

  dual_tick_timer u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Each bus task starts at a falling edge and spends exactly one rising edge.
  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    sb_q.push_back(e);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: a read accepted at a rising edge shows its data by the next falling edge.
  always @(posedge clk) rd_seen <= bus_sel && !bus_wr && !rst;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R2: unexpected read data %h", bus_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(bus_rdata, e.val, e.tag);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check({31'd0, irq}, 32'd0, "R1 irq after reset");
    bus_read(6'h00, 32'd0, "R1 reload A");
    bus_read(6'h04, 32'd0, "R1 count A");
    bus_read(6'h08, 32'd0, "R1 ctrl A");
    bus_read(6'h28, 32'd0, "R1 ctrl B");
    // R3 reload copies into count
    bus_write(6'h00, 32'hFF00_000A);
    bus_read(6'h04, 32'h0000_000A, "R3 count copy");
    bus_read(6'h00, 32'h0000_000A, "R3 reload readback");
    // R5/R7 one-shot at full rate; control write cycle gives no tick
    bus_write(6'h08, 32'h0000_0080);
    bus_read(6'h04, 32'd10, "R5 no tick on control write");
    bus_read(6'h04, 32'd9, "R5 one step per clock");
    idle(9);
    check({31'd0, irq}, 32'd0, "R11 irq lags expiry");
    idle(1);
    check({31'd0, irq}, 32'd1, "R7 one-shot expiry irq");
    bus_read(6'h04, 32'd0, "R7 count stays zero");
    bus_read(6'h08, 32'd0, "R7 enable self-cleared");
    // R9 clear with arbitrary data
    bus_write(6'h0C, 32'hDEAD_BEEF);
    idle(1);
    check({31'd0, irq}, 32'd0, "R9 clear drops irq");
    bus_read(6'h0C, 32'd0, "R2 clear reads zero");
    // R8 periodic reload
    bus_write(6'h00, 32'd3);
    bus_write(6'h08, 32'h0000_00C0);
    bus_read(6'h04, 32'd3, "R8 start");
    bus_read(6'h04, 32'd2, "R8 step");
    bus_read(6'h04, 32'd1, "R8 step");
    bus_read(6'h04, 32'd0, "R8 zero");
    bus_read(6'h04, 32'd3, "R8 reload after expiry");
    bus_read(6'h04, 32'd2, "R8 continues");
    check({31'd0, irq}, 32'd1, "R8 periodic expiry irq");
    bus_read(6'h08, 32'h0000_00C0, "R4 periodic stays enabled");
    bus_write(6'h08, 32'd0);
    bus_write(6'h0C, 32'd0);
    // R6 divide by 16
    bus_write(6'h00, 32'd5);
    bus_write(6'h08, 32'hFFFF_FF37 & 32'h0000_00C4 | 32'h0000_0080);
    idle(15);
    bus_read(6'h04, 32'd5, "R6 div16 before first tick");
    bus_read(6'h04, 32'd4, "R6 div16 first tick");
    bus_read(6'h08, 32'h0000_0084, "R4 control readback");
    bus_write(6'h08, 32'd0);
    // R6 divide by 256, code 10 then code 11
    bus_write(6'h00, 32'd2);
    bus_write(6'h08, 32'h0000_0088);
    idle(255);
    bus_read(6'h04, 32'd2, "R6 div256 before tick");
    bus_read(6'h04, 32'd1, "R6 div256 tick");
    bus_write(6'h08, 32'd0);
    bus_write(6'h00, 32'd2);
    bus_write(6'h08, 32'h0000_008C);
    idle(255);
    bus_read(6'h04, 32'd2, "R6 code 11 before tick");
    bus_read(6'h04, 32'd1, "R6 code 11 tick");
    bus_write(6'h08, 32'd0);
    // R2 second window at 0x20, independent of the first; bit 4 selects nothing
    bus_write(6'h20, 32'h00FF_FFFF);
    bus_read(6'h20, 32'h00FF_FFFF, "R2 reload B");
    bus_read(6'h24, 32'h00FF_FFFF, "R2 count B max zero-extended");
    bus_read(6'h00, 32'd2, "R2 reload A untouched");
    bus_write(6'h10, 32'hFFFF_FFFF);
    bus_read(6'h10, 32'd0, "R2 hole reads zero");
    bus_read(6'h04, 32'd1, "R2 hole write ignored");
    // R10 clear coinciding with expiry on timer B (reload 2, periodic, full rate)
    bus_write(6'h20, 32'd2);
    bus_write(6'h28, 32'h0000_00C0);
    idle(5);
    bus_write(6'h2C, 32'd1);
    bus_write(6'h2C, 32'd1);
    check({31'd0, irq}, 32'd1, "R10 expiry beats clear");
    idle(1);
    check({31'd0, irq}, 32'd0, "R9 later clear drops flag");
    bus_write(6'h28, 32'd0);
    bus_write(6'h2C, 32'd0);
    // R12 zero control and reload
    bus_write(6'h00, 32'd0);
    bus_write(6'h08, 32'd0);
    idle(40);
    check({31'd0, irq}, 32'd0, "R12 no event");
    bus_read(6'h04, 32'd0, "R12 count holds");
    idle(2);
    if (sb_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R2: actual %0d pending reads expected 0", sb_q.size());
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule